// File: doc/BRIEF.md
# Lite UART register front end

This block is the register side of a minimal UART. A simple memory-mapped bus reaches four word registers through a single-cycle strobe: receive data, transmit data, status and control. Received bytes come in on a byte stream with a valid/ready handshake. They are held in an eight-entry circular buffer until software reads them. A write to the transmit register sends its low byte out as a one-cycle strobe, so a serialiser can pick it up. The transmit path never backs up, so it always reports empty.

A single level interrupt is raised from a sticky pending flag, gated by an enable bit in the control register. The flag is set when the receive buffer holds data and when the transmit register is written. Only reset clears it. Serial framing, baud timing and line sampling belong to neighbouring blocks.

Reset is asynchronous and active low. It is expected to be released in step with the clock by a synchronizer outside the block.

Top module: `uart_regfront`

## Requirements
- R1: The word index is the byte address shifted right by two. Index 0 is receive data, 1 is transmit data, 2 is status and 3 is control. A read of index 4 or above returns zero, and a write to index 4 or above changes nothing.
- R2: After reset, status reads 0x00000004, control reads 0, the transmit register reads 0, `irq` is low, `rx_ready` is high and `tx_strobe` is low.
- R3: The receive buffer holds 8 bytes and hands them back in arrival order. A byte is stored when `rx_valid` and `rx_ready` are both high. `rx_ready` is low exactly while 8 bytes are held, and a byte offered then is dropped without changing the count.
- R4: A receive-data read returns the slot at (write pointer − count) mod 8. It removes one byte only if the count is non-zero. On an empty buffer it returns that slot's old content and the count stays 0.
- R5: The status word has these bits: bit 0 is high when the count is non-zero, bit 1 when the count is 8, bit 2 is always 1 and bit 4 is the pending flag. Bit 3, bits 7:5 and bits 31:8 read 0.
- R6: The pending flag is set when the receive buffer is non-empty after a cycle and when the transmit register is written. It stays set until reset.
- R7: `irq` is the pending flag ANDed with control bit 4.
- R8: A transmit write stores the full 32-bit word, which reads back at index 1. On the following cycle `tx_strobe` is high for one cycle with `tx_byte` equal to the low 8 bits.
- R9: A control write stores the value as written. If bit 1 is set, it also clears the receive count and write pointer but leaves the stored bytes in place. This clear wins over a byte arriving in the same cycle. Bit 0 has no effect beyond being stored.
- R10: Writes to the status register are ignored.
- R11: A byte arriving in the same cycle as a receive-data read of a non-full buffer is stored, and the oldest byte is returned and removed. The count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle of a read strobe |
| rx_valid | input | 1 | Incoming byte valid |
| rx_byte | input | BYTE_W (8) | Incoming byte |
| rx_ready | output | 1 | Receive buffer can take a byte |
| tx_strobe | output | 1 | One-cycle pulse per transmit write |
| tx_byte | output | BYTE_W (8) | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: depth 8, 8-bit bytes, a 32-bit data word and a 5-bit byte address. With a 5-bit address, word indices 4 to 7 exist, so the zero-read and ignored-write behaviour of out-of-range indices can be reached. With a depth of 8, the pointer wraps after a few pushes, so the full state, dropped bytes and reads of an empty buffer at a wrapped pointer all show up within short runs. A second reset in the middle of the run gives a state with pending clear, in which a transmit write alone must raise the interrupt.

// File: rtl/uf_pkg.sv
package uf_pkg;

  // Word indices of the register file
  typedef enum logic [1:0] {
    REG_RX   = 2'd0,
    REG_TX   = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  // Status bit positions
  localparam int unsigned ST_RXVALID = 0;
  localparam int unsigned ST_RXFULL  = 1;
  localparam int unsigned ST_TXEMPTY = 2;
  localparam int unsigned ST_TXFULL  = 3;
  localparam int unsigned ST_PEND    = 4;

  // Control bit positions
  localparam int unsigned CT_TXCLR = 0;
  localparam int unsigned CT_RXCLR = 1;
  localparam int unsigned CT_IE    = 4;

  // Decoded bus access
  typedef struct packed {
    logic     in_range;
    reg_sel_e sel;
    logic     rd;
    logic     rd_rx;
    logic     wr_tx;
    logic     wr_ctrl;
  } dec_t;

endpackage

// File: rtl/uf_decode.sv
module uf_decode
  import uf_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output dec_t              dec
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             unused_lsb;

  assign word_idx   = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  always_comb begin
    dec          = '0;
    dec.in_range = (32'(word_idx) < 32'd4);
    dec.sel      = reg_sel_e'(word_idx[1:0]);
    dec.rd       = bus_sel && !bus_we && dec.in_range;
    dec.rd_rx    = dec.rd && (dec.sel == REG_RX);
    dec.wr_tx    = bus_sel && bus_we && dec.in_range && (dec.sel == REG_TX);
    dec.wr_ctrl  = bus_sel && bus_we && dec.in_range && (dec.sel == REG_CTRL);
  end

endmodule

// File: rtl/uf_rx_fifo.sv
module uf_rx_fifo #(
  parameter int unsigned DEPTH  = 8,   // power of two
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              pop,
  input  logic              clear,
  output logic              ready,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_nxt,
  output logic [BYTE_W-1:0] head_data
);

  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PTR_W-1:0]  rd_slot;
  logic [DEPTH-1:0]  slot_we;
  logic              do_push, do_pop;

  assign ready   = (cnt_q < CNT_W'(DEPTH));
  assign do_push = push_valid && ready && !clear;
  assign do_pop  = pop && (cnt_q != '0);
  assign rd_slot = wr_ptr_q - cnt_q[PTR_W-1:0];

  // One write enable per storage slot
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot_we
    assign slot_we[gi] = do_push && (wr_ptr_q == PTR_W'(gi));
  end

  // Next state of pointer and count
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (clear) begin
      wr_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = wr_ptr_q + PTR_W'(1);
      cnt_d = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage: no reset, written only through per-slot enables
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) mem_q[i] <= push_data;
    end
  end

  assign head_data = mem_q[rd_slot];
  assign count     = cnt_q;
  assign count_nxt = cnt_d;

endmodule

// File: rtl/uf_status.sv
module uf_status
  import uf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  count_nxt,
  input  logic              tx_wr,
  input  logic              ctrl_ie,
  output logic [DATA_W-1:0] status_word,
  output logic              pend_q,
  output logic              irq
);

  logic pend_set;

  assign pend_set = (count_nxt != '0) || tx_wr;

  // Sticky pending flag with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_set) begin
      pend_q <= 1'b1;
    end
  end

  always_comb begin
    status_word             = '0;
    status_word[ST_RXVALID] = (count != '0);
    status_word[ST_RXFULL]  = (count == CNT_W'(DEPTH));
    status_word[ST_TXEMPTY] = 1'b1;
    status_word[ST_TXFULL]  = 1'b0;
    status_word[ST_PEND]    = pend_q;
  end

  assign irq = pend_q && ctrl_ie;

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uf_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);

  dec_t              dec;
  logic [CNT_W-1:0]  fifo_count, fifo_count_nxt;
  logic [BYTE_W-1:0] head_data;
  logic [DATA_W-1:0] status_word;
  logic              pend_q;
  logic              rx_clear;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] txreg_q, txreg_d;
  logic [BYTE_W-1:0] txbyte_q, txbyte_d;
  logic              txstb_q, txstb_d;

  uf_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .dec      (dec)
  );

  assign rx_clear = dec.wr_ctrl && bus_wdata[CT_RXCLR];

  uf_rx_fifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_rx_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (rx_valid),
    .push_data  (rx_byte),
    .pop        (dec.rd_rx),
    .clear      (rx_clear),
    .ready      (rx_ready),
    .count      (fifo_count),
    .count_nxt  (fifo_count_nxt),
    .head_data  (head_data)
  );

  uf_status #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .count       (fifo_count),
    .count_nxt   (fifo_count_nxt),
    .tx_wr       (dec.wr_tx),
    .ctrl_ie     (ctrl_q[CT_IE]),
    .status_word (status_word),
    .pend_q      (pend_q),
    .irq         (irq)
  );

  // Next state of the control and transmit registers
  always_comb begin
    ctrl_d   = ctrl_q;
    txreg_d  = txreg_q;
    txbyte_d = txbyte_q;
    txstb_d  = dec.wr_tx;
    if (dec.wr_ctrl) ctrl_d = bus_wdata;
    if (dec.wr_tx) begin
      txreg_d  = bus_wdata;
      txbyte_d = bus_wdata[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      txreg_q  <= '0;
      txbyte_q <= '0;
      txstb_q  <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      txreg_q  <= txreg_d;
      txbyte_q <= txbyte_d;
      txstb_q  <= txstb_d;
    end
  end

  // Read data mux
  always_comb begin
    bus_rdata = '0;
    if (dec.rd) begin
      unique case (dec.sel)
        REG_RX:   bus_rdata = DATA_W'(head_data);
        REG_TX:   bus_rdata = txreg_q;
        REG_STAT: bus_rdata = status_word;
        REG_CTRL: bus_rdata = ctrl_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign tx_strobe = txstb_q;
  assign tx_byte   = txbyte_q;

endmodule

// File: rtl/uf_checker.sv
module uf_checker #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_strobe,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              irq,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              pend_q,
  input logic              ctrl_ie
);

  logic tx_wr, ctrl_clr_wr, rx_rd;

  assign tx_wr       = bus_sel && bus_we  && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign ctrl_clr_wr = bus_sel && bus_we  && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3)) && bus_wdata[1];
  assign rx_rd       = bus_sel && !bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !bus_sel) |=> $stable(fifo_count));

  p_push_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !bus_sel) |=> (fifo_count == $past(fifo_count) + CNT_W'(1)));

  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_valid && fifo_count == '0) |=> (fifo_count == '0));

  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> pend_q);

  p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel && pend_q && ctrl_ie) |=> irq);

  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel && !ctrl_ie) |=> !irq);

  p_tx_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> (tx_strobe && tx_byte == $past(bus_wdata[BYTE_W-1:0])));

  p_tx_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_wr |=> !tx_strobe);

  p_rx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clr_wr |=> (fifo_count == '0));

endmodule

bind uart_regfront uf_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .tx_strobe  (tx_strobe),
  .tx_byte    (tx_byte),
  .irq        (irq),
  .fifo_count (fifo_count),
  .pend_q     (pend_q),
  .ctrl_ie    (ctrl_q[4])
);

// File: tb/uart_regfront_tb_top.sv
module uart_regfront_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int DEPTH  = 8;

  logic              clk;
  logic              rst_n;
  logic              bus_sel, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              rx_valid;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_ready;
  logic              tx_strobe;
  logic [BYTE_W-1:0] tx_byte;
  logic              irq;

  uart_regfront #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference model state
  logic [7:0]  m_mem [8];
  bit          m_vld [8];
  int          m_ptr, m_cnt;
  bit          m_pend;
  logic [31:0] m_ctrl, m_tx;

  function automatic logic [31:0] exp_status();
    return {24'b0, 3'b0, m_pend, 1'b0, 1'b1, (m_cnt == 8), (m_cnt != 0)};
  endfunction

  function automatic int head_slot();
    return (m_ptr - m_cnt) & 7;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ptr = 0; m_cnt = 0; m_pend = 0; m_ctrl = '0; m_tx = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic bus_wr(int addr, logic [31:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(int addr, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(addr);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    #1 check("R3", "rx_ready before push", 32'(rx_ready), 32'(m_cnt < 8));
    if (m_cnt < 8) begin
      m_mem[m_ptr] = b; m_vld[m_ptr] = 1; m_ptr = (m_ptr + 1) & 7; m_cnt++;
    end
    if (m_cnt != 0) m_pend = 1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rd_rx(string req);
    logic [31:0] d;
    logic [31:0] e;
    e = {24'b0, m_mem[head_slot()]};
    bus_rd(0, d);
    check(req, "rx data", d, e);
    if (m_cnt > 0) m_cnt--;
  endtask

  task automatic wr_ctrl(logic [31:0] v);
    bus_wr(12, v);
    m_ctrl = v;
    if (v[1]) begin m_ptr = 0; m_cnt = 0; end
  endtask

  task automatic wr_tx(logic [31:0] v);
    bus_wr(4, v);
    check("R8", "tx_strobe after write", 32'(tx_strobe), 32'd1);
    check("R8", "tx_byte", 32'(tx_byte), {24'b0, v[7:0]});
    m_tx = v; m_pend = 1;
    @(negedge clk);
    check("R8", "tx_strobe one cycle", 32'(tx_strobe), 32'd0);
  endtask

  task automatic chk_status(string req);
    logic [31:0] d;
    bus_rd(8, d);
    check(req, "status", d, exp_status());
  endtask

  task automatic chk_pins();
    check("R7", "irq", 32'(irq), 32'(m_pend & m_ctrl[4]));
    check("R3", "rx_ready", 32'(rx_ready), 32'(m_cnt < 8));
    check("R8", "tx_strobe idle", 32'(tx_strobe), 32'd0);
  endtask

  initial begin
    @(posedge done);
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  first3;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 1'b0; rx_byte = '0;
    for (int i = 0; i < 8; i++) begin m_mem[i] = '0; m_vld[i] = 0; end
    model_reset();
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    check("R2", "irq after reset", 32'(irq), 32'd0);
    check("R2", "rx_ready after reset", 32'(rx_ready), 32'd1);
    check("R2", "tx_strobe after reset", 32'(tx_strobe), 32'd0);
    bus_rd(8, d);  check("R2", "status after reset", d, 32'h4);
    bus_rd(12, d); check("R2", "control after reset", d, 32'h0);
    bus_rd(4, d);  check("R2", "tx reg after reset", d, 32'h0);

    // R7 / R9: enable interrupt, no pending yet
    wr_ctrl(32'h0000_0010);
    bus_rd(12, d); check("R9", "control readback", d, 32'h10);
    chk_pins();

    // R3 / R5: fill the buffer
    for (int i = 0; i < 8; i++) push(8'h30 + 8'(i));
    chk_status("R5");
    check("R5", "full status value", exp_status(), 32'h17);
    check("R3", "ready low when full", 32'(rx_ready), 32'd0);
    chk_pins();
    push(8'hEE); // dropped
    chk_status("R3");
    for (int i = 0; i < 8; i++) rd_rx("R3");
    chk_status("R5");

    // R4: empty read returns slot at pointer (slot 0 = 0x30), count stays 0
    rd_rx("R4");
    check("R4", "empty read value", {24'b0, m_mem[0]}, 32'h30);
    chk_status("R4");

    // R10: status write ignored
    bus_wr(8, 32'hFFFF_FFFF);
    chk_status("R10");

    // R7: gate by control bit 4
    wr_ctrl(32'h0000_0000); chk_pins();
    check("R7", "irq masked", 32'(irq), 32'd0);
    wr_ctrl(32'h0000_0011); chk_pins();
    check("R7", "irq enabled", 32'(irq), 32'd1);

    // R8: transmit
    wr_tx(32'h1234_A5C3);
    bus_rd(4, d); check("R8", "tx reg readback", d, 32'h1234_A5C3);

    // R1: out-of-range indices
    for (int k = 4; k < 8; k++) begin
      bus_wr(k * 4, 32'hDEAD_BEEF);
      bus_rd(k * 4, d); check("R1", "high index reads zero", d, 32'h0);
    end
    bus_rd(12, d); check("R1", "control untouched by high write", d, m_ctrl);
    bus_rd(4, d);  check("R1", "tx untouched by high write", d, m_tx);
    bus_rd(13, d); check("R1", "low address bits ignored", d, m_ctrl);

    // R9: clear with simultaneous arriving byte
    push(8'h71); push(8'h72); push(8'h73);
    first3 = 8'h71;
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h99;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'd12; bus_wdata = 32'h0000_0012;
    @(negedge clk);
    rx_valid = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    m_ctrl = 32'h12; m_ptr = 0; m_cnt = 0;
    chk_status("R9");
    bus_rd(12, d); check("R9", "control stored as written", d, 32'h12);
    rd_rx("R9");
    check("R9", "storage kept after clear", {24'b0, m_mem[0]}, {24'b0, first3});

    // R11: push and pop in the same cycle
    push(8'h41); push(8'h42);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h43;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'd0;
    #1 check("R11", "rx data on simultaneous pop", bus_rdata, {24'b0, m_mem[head_slot()]});
    m_cnt--;
    m_mem[m_ptr] = 8'h43; m_vld[m_ptr] = 1; m_ptr = (m_ptr + 1) & 7; m_cnt++;
    @(negedge clk);
    rx_valid = 1'b0; bus_sel = 1'b0;
    chk_status("R11");
    check("R11", "count unchanged", 32'(m_cnt), 32'd2);
    rd_rx("R11"); rd_rx("R11");

    // R6: after reset, a transmit write alone raises pending
    do_reset();
    chk_status("R2");
    wr_ctrl(32'h10);
    check("R6", "no pending before tx", 32'(irq), 32'd0);
    wr_tx(32'h0000_0055);
    check("R6", "pending from tx write", 32'(irq), 32'd1);
    chk_status("R6");

    // Constrained random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2, 3: push(8'($urandom));
        4, 5: if (m_cnt > 0 || m_vld[head_slot()]) rd_rx("R3");
        6: chk_status("R5");
        7: begin
          logic [31:0] v;
          v = $urandom & 32'hFFFF_FFFD;
          if ($urandom_range(0, 7) == 0) v[1] = 1'b1;
          wr_ctrl(v);
        end
        8: wr_tx($urandom);
        default: begin
          int k;
          k = $urandom_range(4, 7);
          bus_wr(k * 4, $urandom);
          bus_rd(k * 4, d); check("R1", "random high index", d, 32'h0);
          bus_rd(12, d); check("R9", "random control readback", d, m_ctrl);
        end
      endcase
      chk_pins();
    end
    chk_status("R6");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule